// File: doc/BRIEF.md
# Table-Indirect Parameter Fetch Unit

This block performs the parameter load step of a table-indirect opcode inside a script-driven bus-master controller. The opcode has already been fetched. The block receives a start strobe with the opcode's mode bit and its 24-bit signed offset, together with the current value of the 32-bit base register. When the mode bit is set, the block sign-extends the offset and adds it to the base to form a data address. It then issues exactly one 32-bit read on a request/grant memory port.

The returned dword carries three parameter bytes and one reserved byte. The block writes the three parameter bytes to the configuration, device ID and synchronous offset/period registers with three write strobes that fire in the same cycle. A completion pulse follows those strobes. Two faults end the operation early, each with its own one-cycle pulse and with no register written:

- an address that is not dword aligned;
- a bus error on the read.

Top module: `tif_fetch`

## Requirements
- R1: After reset, rd_req_o, all three write strobes, done_o, err_o and misalign_o are low.
- R2: A start_i pulse while tbl_ind_i is low has no effect: no read is requested and no status pulse follows.
- R3: The read address is base_i plus offset_i sign-extended from bit 23, computed as a full 32-bit add that wraps modulo 2^32. It is latched in the cycle start_i is taken.
- R4: If bits 1:0 of the computed address are not both zero, misalign_o pulses for one cycle in the cycle after start and no read is requested.
- R5: rd_req_o rises in the cycle after an aligned start. It stays high with a stable rd_addr_o until a cycle in which rd_gnt_i is high, and then drops. Only one read is issued per operation.
- R6: Byte lanes of the read data: bits 23:16 go to cfg_o, bits 15:8 go to id_o, bits 7:0 go to xfer_o. Bits 31:24 are ignored.
- R7: Once a response without error arrives (rd_valid_i high after the grant), cfg_we_o, id_we_o and xfer_we_o are high together for exactly the next cycle.
- R8: done_o pulses for one cycle, in the cycle after the write strobes.
- R9: A response with rd_err_i high makes err_o pulse for one cycle in the following cycle, and no write strobe fires.
- R10: start_i is ignored while an operation is in progress. The latched address and the outcome of the operation do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opcode fetched, begin parameter load |
| tbl_ind_i | input | 1 | Table-indirect mode bit of the opcode |
| offset_i | input | 24 | Signed offset field of the opcode |
| base_i | input | 32 | Base register value |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read address |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_valid_i | input | 1 | Read response valid |
| rd_err_i | input | 1 | Read response is a bus error |
| rd_data_i | input | 32 | Read response data |
| cfg_we_o | output | 1 | Configuration register write strobe |
| cfg_o | output | 8 | Configuration byte |
| id_we_o | output | 1 | Device ID register write strobe |
| id_o | output | 8 | Device ID byte |
| xfer_we_o | output | 1 | Offset/period register write strobe |
| xfer_o | output | 8 | Offset/period byte |
| done_o | output | 1 | Load completed |
| err_o | output | 1 | Load aborted by bus error |
| misalign_o | output | 1 | Load refused, address not dword aligned |

## Verification
Random bases are paired with offsets of both signs, so address arithmetic on sign extension and carry is exercised. Directed cases use the largest positive and most negative offsets and a base near the top of the address space, which exposes a wrong or missing 32-bit wrap. Random data with a nonzero top byte separates the correct lane mapping from shifted or swapped lanes. Grant and response delays from zero to several cycles, random bus errors, offsets with nonzero low bits, mode-clear starts and starts during a busy operation separate the abort paths and the request hold from the normal load sequence.

// File: rtl/tif_pkg.sv
package tif_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_LOAD = 2'd2
  } tif_state_e;

  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] id;
    logic [7:0] xfer;
  } tif_regs_t;
endpackage

// File: rtl/tif_addr_gen.sv
module tif_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 24,
  parameter int ALIGN_W = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              misalign_o
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;

  assign off_ext    = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  // plain modulo add: table may straddle any segment boundary
  assign addr_o     = base_i + off_ext;
  assign misalign_o = |addr_o[ALIGN_W-1:0];
endmodule

// File: rtl/tif_unpack.sv
module tif_unpack
  import tif_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_i,
  output tif_regs_t         regs_o
);
  localparam int BYTE_W   = 8;
  localparam int LANE_XFR = 0;
  localparam int LANE_ID  = 1;
  localparam int LANE_CFG = 2;
  localparam int LANE_RSV = 3;

  logic unused_rsv;

  assign regs_o.xfer = word_i[LANE_XFR*BYTE_W +: BYTE_W];
  assign regs_o.id   = word_i[LANE_ID*BYTE_W  +: BYTE_W];
  assign regs_o.cfg  = word_i[LANE_CFG*BYTE_W +: BYTE_W];
  assign unused_rsv  = ^word_i[LANE_RSV*BYTE_W +: BYTE_W];
endmodule

// File: rtl/tif_ctrl.sv
module tif_ctrl
  import tif_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tbl_ind_i,
  input  logic              misalign_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_valid_i,
  input  logic              rd_err_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              load_o,
  output logic [DATA_W-1:0] word_o,
  output logic              done_o,
  output logic              err_o,
  output logic              misalign_o
);
  tif_state_e        state_q;
  logic              granted_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] word_q;
  logic              done_q, err_q, mis_q;
  logic              rsp_take;

  assign rsp_take = (state_q == ST_PEND) && granted_q && rd_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      granted_q <= 1'b0;
      addr_q    <= '0;
      word_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      mis_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      mis_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && tbl_ind_i) begin
            if (misalign_i) begin
              mis_q <= 1'b1;
            end else begin
              addr_q    <= addr_i;
              granted_q <= 1'b0;
              state_q   <= ST_PEND;
            end
          end
        end
        ST_PEND: begin
          if (!granted_q) begin
            if (rd_gnt_i) granted_q <= 1'b1;
          end else if (rd_valid_i) begin
            if (rd_err_i) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              word_q  <= rd_data_i;
              state_q <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o   = (state_q == ST_PEND) && !granted_q;
  assign rd_addr_o  = addr_q;
  assign load_o     = (state_q == ST_LOAD);
  assign word_o     = word_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign misalign_o = mis_q;

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_gnt_i |=> rd_req_o && $stable(rd_addr_o));

  p_req_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_gnt_i |=> !rd_req_o);

  p_aligned_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[1:0] == 2'b00);

  p_done_after_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> done_o && !load_o);

  p_err_no_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_take && rd_err_i |=> err_o && !load_o);

  p_mode_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && start_i && !tbl_ind_i |=> !rd_req_o && !misalign_o);

  p_one_status_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o, misalign_o, load_o}));
endmodule

// File: rtl/tif_fetch.sv
module tif_fetch
  import tif_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tbl_ind_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_valid_i,
  input  logic              rd_err_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              cfg_we_o,
  output logic [7:0]        cfg_o,
  output logic              id_we_o,
  output logic [7:0]        id_o,
  output logic              xfer_we_o,
  output logic [7:0]        xfer_o,
  output logic              done_o,
  output logic              err_o,
  output logic              misalign_o
);
  logic [ADDR_W-1:0] calc_addr;
  logic              calc_mis;
  logic              load;
  logic [DATA_W-1:0] word;
  tif_regs_t         regs;

  tif_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base_i    (base_i),
    .off_i     (offset_i),
    .addr_o    (calc_addr),
    .misalign_o(calc_mis)
  );

  tif_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .tbl_ind_i (tbl_ind_i),
    .misalign_i(calc_mis),
    .addr_i    (calc_addr),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_gnt_i  (rd_gnt_i),
    .rd_valid_i(rd_valid_i),
    .rd_err_i  (rd_err_i),
    .rd_data_i (rd_data_i),
    .load_o    (load),
    .word_o    (word),
    .done_o    (done_o),
    .err_o     (err_o),
    .misalign_o(misalign_o)
  );

  tif_unpack #(.DATA_W(DATA_W)) u_unpack (
    .word_i(word),
    .regs_o(regs)
  );

  // one dword fills all three targets in the same cycle
  assign cfg_we_o  = load;
  assign id_we_o   = load;
  assign xfer_we_o = load;
  assign cfg_o     = regs.cfg;
  assign id_o      = regs.id;
  assign xfer_o    = regs.xfer;

  p_addr_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_o) |-> rd_addr_o ==
      $past(base_i) + {{(ADDR_W-OFF_W){$past(offset_i[OFF_W-1])}}, $past(offset_i)});

  p_lanes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_we_o) |-> {cfg_o, id_o, xfer_o} == $past(rd_data_i[23:0]));
endmodule

// File: tb/tif_fetch_bench.sv
module tif_fetch_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, tbl_ind_i = 1'b0;
  logic [23:0] offset_i = '0;
  logic [31:0] base_i = '0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_gnt_i = 1'b0, rd_valid_i = 1'b0, rd_err_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        cfg_we_o, id_we_o, xfer_we_o, done_o, err_o, misalign_o;
  logic [7:0]  cfg_o, id_o, xfer_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2 clk_i = ~clk_i;

  tif_fetch u_tif_fetch (.*);

  function automatic logic [31:0] exp_addr(logic [31:0] b, logic [23:0] o);
    return b + {{8{o[23]}}, o};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_quiet(string req);
    chk(!rd_req_o && !cfg_we_o && !id_we_o && !xfer_we_o && !done_o && !err_o && !misalign_o,
        req, {25'd0, rd_req_o, cfg_we_o, id_we_o, xfer_we_o, done_o, err_o, misalign_o}, 32'd0);
  endtask

  // one operation; inputs change on negedge, outputs read on negedge
  task automatic run_op(logic [31:0] b, logic [23:0] o, bit mode, int gdly, int rdly,
                        logic [31:0] data, bit berr, bit poke);
    logic [31:0] ea;
    ea = exp_addr(b, o);
    @(negedge clk_i);
    start_i = 1'b1; tbl_ind_i = mode; base_i = b; offset_i = o;
    @(negedge clk_i);
    start_i = 1'b0;
    if (!mode) begin
      idle_quiet("R2");
      @(negedge clk_i);
      idle_quiet("R2");
      return;
    end
    if (ea[1:0] != 2'b00) begin
      chk(misalign_o && !rd_req_o, "R4", {30'd0, misalign_o, rd_req_o}, 32'd2);
      @(negedge clk_i);
      idle_quiet("R4");
      return;
    end
    chk(rd_req_o && rd_addr_o == ea, "R3", rd_addr_o, ea);
    for (int i = 0; i < gdly; i++) begin
      if (poke && i == 0) begin
        start_i = 1'b1; tbl_ind_i = 1'b1; base_i = ~b; offset_i = o + 24'd4;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      chk(rd_req_o && rd_addr_o == ea, poke ? "R10" : "R5", rd_addr_o, ea);
    end
    rd_gnt_i = 1'b1;
    @(negedge clk_i);
    rd_gnt_i = 1'b0;
    chk(!rd_req_o, "R5", {31'd0, rd_req_o}, 32'd0);
    for (int i = 0; i < rdly; i++) begin
      if (poke && i == 0) begin
        start_i = 1'b1; tbl_ind_i = 1'b1; base_i = b + 32'd8; offset_i = 24'd0;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      chk(!rd_req_o && !cfg_we_o, poke ? "R10" : "R5", {30'd0, rd_req_o, cfg_we_o}, 32'd0);
    end
    rd_valid_i = 1'b1; rd_err_i = berr; rd_data_i = data;
    @(negedge clk_i);
    rd_valid_i = 1'b0; rd_err_i = 1'b0; rd_data_i = $urandom;
    if (berr) begin
      chk(err_o && !cfg_we_o && !id_we_o && !xfer_we_o, "R9",
          {28'd0, err_o, cfg_we_o, id_we_o, xfer_we_o}, 32'h8);
      @(negedge clk_i);
      idle_quiet("R9");
    end else begin
      chk(cfg_we_o && id_we_o && xfer_we_o && !done_o, "R7",
          {28'd0, cfg_we_o, id_we_o, xfer_we_o, done_o}, 32'he);
      chk({cfg_o, id_o, xfer_o} == data[23:0], "R6",
          {8'd0, cfg_o, id_o, xfer_o}, {8'd0, data[23:0]});
      @(negedge clk_i);
      chk(done_o && !cfg_we_o && !id_we_o && !xfer_we_o, "R8",
          {28'd0, done_o, cfg_we_o, id_we_o, xfer_we_o}, 32'h8);
      chk(!rd_req_o, "R5", {31'd0, rd_req_o}, 32'd0);
      @(negedge clk_i);
      idle_quiet("R8");
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk_i);
    idle_quiet("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle_quiet("R1");

    run_op(32'h0000_1000, 24'h00_0010, 1'b0, 0, 0, 32'h0, 1'b0, 1'b0);   // R2
    run_op(32'h1000_0000, 24'h7F_FFFC, 1'b1, 0, 0, 32'hA5_3C_7E_11, 1'b0, 1'b0);  // R3 max positive
    run_op(32'h1000_0000, 24'h80_0000, 1'b1, 2, 1, 32'hFF_01_02_03, 1'b0, 1'b0);  // R3 most negative
    run_op(32'hFFFF_FFFC, 24'h00_0008, 1'b1, 1, 0, 32'h00_80_40_20, 1'b0, 1'b0);  // R3 wrap up
    run_op(32'h0000_0000, 24'hFF_FFFC, 1'b1, 0, 2, 32'h12_34_56_78, 1'b0, 1'b0);  // R3 wrap down
    run_op(32'h0000_2000, 24'h00_0001, 1'b1, 0, 0, 32'h0, 1'b0, 1'b0);   // R4
    run_op(32'h0000_2000, 24'h00_0002, 1'b1, 0, 0, 32'h0, 1'b0, 1'b0);   // R4
    run_op(32'h0000_3000, 24'h00_0040, 1'b1, 3, 3, 32'hDE_AD_BE_EF, 1'b1, 1'b1);  // R9, R10
    run_op(32'h0000_4000, 24'h00_0044, 1'b1, 2, 2, 32'hCA_FE_F0_0D, 1'b0, 1'b1);  // R10

    for (int n = 0; n < 400; n++) begin
      logic [31:0] b, d, r;
      logic [23:0] o;
      b = {$urandom, 2'b00} ;
      r = $urandom;
      o = (r[2:0] == 3'd0) ? r[31:8] : {r[31:10], 2'b00};
      d = $urandom;
      run_op(b, o, (r[6:3] != 4'd0), int'(r[8:7]) + ((r[9]) ? 2 : 0), int'(r[5:4]),
             d, (r[9:7] == 3'd5), (r[3:1] == 3'd6));
    end
    repeat (2) @(negedge clk_i);
    idle_quiet("R1");
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end
endmodule